// File: doc/BRIEF.md
# Channel Divider with Coarse Phase Delay

This block divides a fast input clock by a programmable integer ratio and produces a registered divided waveform. The output stays high for a programmed number of input cycles, then low for a programmed number, and repeats. Both counts are loaded from 4-bit fields that hold the count minus one.

A 5-bit phase value delays the first rising edge of the divided output by a whole number of input cycles. The delay is measured against a divider whose phase is zero. The phase value is formed from a start-high bit and a 4-bit offset field. Below 16 the delay equals the phase value. From 16 upward the delay also includes the low-cycle count.

A synchronization input reloads all counters and applies the programmed phase. Several dividers that share a clock and a sync pulse can therefore be given fixed output-to-output skews, in steps of one input cycle.

Top module: `phase_divider`

## Requirements
- R1: While rst_ni is low, div_o is 0.
- R2: In free run, div_o stays high for exactly high_cnt_i+1 consecutive input cycles, where high_cnt_i is an unsigned 4-bit value.
- R3: In free run, div_o stays low for exactly low_cnt_i+1 consecutive input cycles, where low_cnt_i is an unsigned 4-bit value. The period is therefore high_cnt_i+low_cnt_i+2 cycles.
- R4: The phase value is P = 16*start_high_i + offset_i, where offset_i is an unsigned 4-bit value, so 0 <= P <= 31.
- R5: Let edge E0 be the first rising clock edge that samples sync_i low after a sync. A zero-delay divider drives div_o to 1 right after E0. For P <= 15, div_o first rises right after edge E0+P, which is P cycles later than the zero-delay case.
- R6: For P >= 16, div_o first rises right after edge E0+(P-16+low_cnt_i+1).
- R7: Every clock edge that samples sync_i high forces div_o to 0 and reloads the delay from the current phase inputs and low_cnt_i.
- R8: Changes to offset_i or start_high_i while sync_i is low have no effect on div_o.
- R9: A change to high_cnt_i or low_cnt_i while sync_i is low takes effect at the next rising edge of div_o. The high and low phases already under way finish with their old lengths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Divider input clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sync_i | input | 1 | Synchronization; reloads counters and phase |
| high_cnt_i | input | 4 | High-time count minus one |
| low_cnt_i | input | 4 | Low-time count minus one |
| offset_i | input | 4 | Phase offset field, low four bits of the phase value |
| start_high_i | input | 1 | Phase bit of weight 16 |
| div_o | output | 1 | Divided output |

## Verification
Every phase value from 0 to 31 is applied after a sync. Each one is paired with a low count of 0, of 15, or a random value, so the bench can tell the two forms of the delay formula apart, including how the upper form depends on the low count. After each sync the bench measures the delay to the first rising edge and then the high and low run lengths, which separates an off-by-one in the delay path from one in the period path. Directed cases cover the following:
- holding sync for several cycles;
- changing the count fields in the middle of a period, to check that they take effect only at a period boundary;
- changing the phase fields without a sync, to check that the running waveform does not move.

// File: rtl/phase_div_pkg.sv
package phase_div_pkg;
  localparam int unsigned CNT_W_DEF = 4;
  localparam int unsigned OFS_W_DEF = 4;

  function automatic int unsigned max_u(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/phase_decode.sv
module phase_decode
  import phase_div_pkg::*;
#(
  parameter int unsigned CNT_W = CNT_W_DEF,
  parameter int unsigned OFS_W = OFS_W_DEF,
  localparam int unsigned DLY_W = max_u(CNT_W, OFS_W) + 1
) (
  input  logic             start_high_i,
  input  logic [OFS_W-1:0] offset_i,
  input  logic [CNT_W-1:0] low_cnt_i,
  output logic [DLY_W-1:0] delay_o
);
  logic [DLY_W-1:0] ofs_ext, low_ext;

  assign ofs_ext = DLY_W'(offset_i);
  assign low_ext = DLY_W'(low_cnt_i);

  // Upper phase range: the wait also includes the low time.
  always_comb begin
    if (start_high_i) delay_o = ofs_ext + low_ext + DLY_W'(1);
    else              delay_o = ofs_ext;
  end
endmodule

// File: rtl/delay_ctrl.sv
module delay_ctrl #(
  parameter int unsigned DLY_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sync_i,
  input  logic [DLY_W-1:0] delay_i,
  output logic             fire_o,
  output logic             run_o
);
  logic             wait_q;
  logic [DLY_W-1:0] dly_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wait_q <= 1'b1;
      dly_q  <= '0;
    end else if (sync_i) begin
      wait_q <= 1'b1;
      dly_q  <= delay_i;
    end else if (wait_q) begin
      if (dly_q == '0) wait_q <= 1'b0;
      else             dly_q  <= dly_q - DLY_W'(1);
    end
  end

  assign fire_o = wait_q & ~sync_i & (dly_q == '0);
  assign run_o  = ~wait_q;

  // R5
  dly_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wait_q && !sync_i && dly_q != '0) |=> (wait_q && dly_q == $past(dly_q) - DLY_W'(1)));

  // R6
  fire_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |=> !wait_q);
endmodule

// File: rtl/period_gen.sv
module period_gen #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sync_i,
  input  logic             fire_i,
  input  logic             run_i,
  input  logic [CNT_W-1:0] high_cnt_i,
  input  logic [CNT_W-1:0] low_cnt_i,
  output logic             div_o
);
  logic             out_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] low_q;
  logic [CNT_W-1:0] high_tgt_q;

  // Counts are sampled at each rising edge, so a period is never split.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q      <= 1'b0;
      cnt_q      <= '0;
      low_q      <= '0;
      high_tgt_q <= '0;
    end else if (sync_i) begin
      out_q <= 1'b0;
      cnt_q <= '0;
    end else if (fire_i) begin
      out_q      <= 1'b1;
      cnt_q      <= high_cnt_i;
      low_q      <= low_cnt_i;
      high_tgt_q <= high_cnt_i;
    end else if (run_i) begin
      if (cnt_q == '0) begin
        if (out_q) begin
          out_q <= 1'b0;
          cnt_q <= low_q;
        end else begin
          out_q      <= 1'b1;
          cnt_q      <= high_cnt_i;
          low_q      <= low_cnt_i;
          high_tgt_q <= high_cnt_i;
        end
      end else begin
        cnt_q <= cnt_q - CNT_W'(1);
      end
    end
  end

  assign div_o = out_q;

  logic [CNT_W:0] hi_len_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    hi_len_q <= '0;
    else if (out_q) hi_len_q <= hi_len_q + (CNT_W+1)'(1);
    else            hi_len_q <= '0;
  end

  // R7
  sync_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_i |=> !out_q);

  // R2
  high_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!out_q && $past(out_q) && !$past(sync_i)) |->
      hi_len_q == (CNT_W+1)'(high_tgt_q) + (CNT_W+1)'(1));

  // R3
  low_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !out_q && !sync_i) |-> cnt_q <= low_q);
endmodule

// File: rtl/phase_divider.sv
module phase_divider
  import phase_div_pkg::*;
#(
  parameter int unsigned CNT_W = CNT_W_DEF,
  parameter int unsigned OFS_W = OFS_W_DEF,
  localparam int unsigned DLY_W = max_u(CNT_W, OFS_W) + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sync_i,
  input  logic [CNT_W-1:0] high_cnt_i,
  input  logic [CNT_W-1:0] low_cnt_i,
  input  logic [OFS_W-1:0] offset_i,
  input  logic             start_high_i,
  output logic             div_o
);
  logic [DLY_W-1:0] delay;
  logic             fire, run;

  phase_decode #(.CNT_W(CNT_W), .OFS_W(OFS_W)) u_decode (
    .start_high_i(start_high_i),
    .offset_i    (offset_i),
    .low_cnt_i   (low_cnt_i),
    .delay_o     (delay)
  );

  delay_ctrl #(.DLY_W(DLY_W)) u_delay (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sync_i (sync_i),
    .delay_i(delay),
    .fire_o (fire),
    .run_o  (run)
  );

  period_gen #(.CNT_W(CNT_W)) u_period (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sync_i    (sync_i),
    .fire_i    (fire),
    .run_i     (run),
    .high_cnt_i(high_cnt_i),
    .low_cnt_i (low_cnt_i),
    .div_o     (div_o)
  );

  // R1
  reset_low_chk: assert property (@(posedge clk_i) !rst_ni |-> !div_o);
endmodule

// File: tb/phase_divider_tb.sv
module phase_divider_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sync_i = 1'b0;
  logic [3:0] high_cnt_i = '0;
  logic [3:0] low_cnt_i = '0;
  logic [3:0] offset_i = '0;
  logic       start_high_i = 1'b0;
  logic       div_o;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  phase_divider u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .sync_i(sync_i),
    .high_cnt_i(high_cnt_i), .low_cnt_i(low_cnt_i),
    .offset_i(offset_i), .start_high_i(start_high_i), .div_o(div_o)
  );

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles, expected < %0d", cycles, WATCHDOG);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  function automatic int exp_delay(int phi, int m);
    return (phi <= 15) ? phi : (phi - 16 + m + 1);
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_sync(int hold);
    @(negedge clk_i) sync_i = 1'b1;
    repeat (hold) @(negedge clk_i);
    sync_i = 1'b0;
  endtask

  // Called right after sync release at a negedge.
  task automatic meas_delay(output int k);
    k = 0;
    @(negedge clk_i);
    while (!div_o && k < 200) begin k++; @(negedge clk_i); end
  endtask

  task automatic meas_run(logic lvl, output int len);
    len = 0;
    while (div_o == lvl && len < 200) begin len++; @(negedge clk_i); end
  endtask

  initial begin
    int k, h, l;
    int n, m, phi;
    void'($urandom(32'd5150));

    // R1: reset state
    repeat (3) @(negedge clk_i) check("R1", int'(div_o), 0);
    rst_ni = 1'b1;

    // R7: output held low while sync asserted
    high_cnt_i = 4'd2; low_cnt_i = 4'd2;
    @(negedge clk_i) sync_i = 1'b1;
    repeat (5) @(negedge clk_i) check("R7", int'(div_o), 0);
    sync_i = 1'b0;
    meas_delay(k);
    check("R7 reload delay", k, 0);

    // R4 R5 R6 R2 R3: sweep all phase values
    for (int p = 0; p < 32; p++) begin
      phi = p;
      n = $urandom % 16;
      case (p % 4)
        0: m = 0;
        1: m = 15;
        default: m = $urandom % 16;
      endcase
      high_cnt_i   = 4'(n);
      low_cnt_i    = 4'(m);
      offset_i     = 4'(phi % 16);
      start_high_i = (phi >= 16);
      do_sync(1 + ($urandom % 3));
      meas_delay(k);
      check(phi <= 15 ? "R5" : "R6", k, exp_delay(phi, m));
      meas_run(1'b1, h);
      check("R2", h, n + 1);
      meas_run(1'b0, l);
      check("R3", l, m + 1);
    end

    // R9: counts changed mid-period apply at next rising edge
    high_cnt_i = 4'd3; low_cnt_i = 4'd5; offset_i = 4'd0; start_high_i = 1'b0;
    do_sync(1);
    meas_delay(k);
    @(negedge clk_i);
    high_cnt_i = 4'd7; low_cnt_i = 4'd1;
    meas_run(1'b1, h);
    check("R9 old high", h + 1, 4);
    meas_run(1'b0, l);
    check("R9 old low", l, 6);
    meas_run(1'b1, h);
    check("R9 new high", h, 8);
    meas_run(1'b0, l);
    check("R9 new low", l, 2);

    // R8: phase change without sync leaves waveform untouched
    high_cnt_i = 4'd4; low_cnt_i = 4'd4;
    do_sync(1);
    meas_delay(k);
    check("R8 base delay", k, 0);
    offset_i = 4'd9; start_high_i = 1'b1;
    meas_run(1'b1, h);
    check("R8 high", h, 5);
    meas_run(1'b0, l);
    check("R8 low", l, 5);
    meas_run(1'b1, h);
    check("R8 high2", h, 5);
    // R4: later sync applies new phase 16+9 with low 4
    do_sync(2);
    meas_delay(k);
    check("R4 applied", k, exp_delay(25, 4));

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule